// File: doc/BRIEF.md
# Glitch-Free Termination Update Sequencer

This block sits on the controller side of a DDR2-style memory channel and changes the nominal on-die termination value of the device without the termination briefly taking an undefined value. The normal owner of the termination-enable pin drives it through this block while nothing is happening. When a request arrives, the block takes over that pin and forces it low. It waits until the device has had time to switch termination fully off, then issues one extended mode register write to the termination register with the new two-bit resistance code. It then keeps the command bus quiet and the pin low for the whole worst-case register update time. It finishes with a one-cycle acknowledge and hands the pin back.

The two code bits go to two address lines that are not next to each other: address bit 6 takes code bit 1 and address bit 2 takes code bit 0. Every other address bit of the register write comes from a held shadow of the register contents. That shadow starts from a parameter value and afterwards always holds the last value written, so unrelated settings in that register stay as they were. The turn-off delay and the maximum update delay are parameters in clock cycles. One down-counter serves both waits.

Top module: `rtt_update_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block is idle: `odt_o` equals `odt_owner_i`, `cmd_o` is NOP (3'b111), `bank_o` and `addr_o` are zero, and `ack_o` is low.
- R2: While idle, `odt_o` follows `odt_owner_i` in the same cycle, and `cmd_o` is NOP.
- R3: A request is accepted at a clock edge where the block is idle and `req_i` is high. From the next cycle through the acknowledge cycle, `odt_o` is low whatever `odt_owner_i` does.
- R4: Exactly T_AOFD cycles after the accepting edge come cycles with `odt_o` low and NOP on the bus. On the cycle after them comes a single register write: `cmd_o` = 3'b000 with `bank_o` = 1, which selects the termination register.
- R5: During the register write, `addr_o[6]` equals `rtt_i[1]` and `addr_o[2]` equals `rtt_i[0]`, both as sampled at the accepting edge. All other address bits equal the shadow, which after reset is EMR1_INIT.
- R6: The register write is followed by exactly T_MOD_MAX cycles of NOP with `odt_o` low. On the next cycle `ack_o` is high for exactly one cycle, and on the cycle after that the block is idle again.
- R7: Changes on `req_i` and `rtt_i` between acceptance and acknowledge do not affect the sequence or the code written.
- R8: The shadow keeps the last written code: a later write repeats all bits except 6 and 2 unchanged. While idle, `bank_o` and `addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request a termination update |
| rtt_i | input | 2 | New nominal termination code |
| ack_o | output | 1 | One-cycle completion pulse |
| odt_owner_i | input | 1 | Termination enable from the normal owner |
| odt_o | output | 1 | Termination enable to the device |
| cmd_o | output | 3 | Command as {ras_n, cas_n, we_n}: 3'b111 NOP, 3'b000 register write |
| bank_o | output | BANK_W | Bank address (1 selects the termination register) |
| addr_o | output | ADDR_W | Address bus |

## Verification
If the state register or the shared counter goes wrong, the register write comes out at the wrong cycle offset. The termination pin is released early, or the acknowledge comes at the wrong distance from the write. A scoreboard that compares every cycle of a sequence shows such an error in the first cycle where it happens. A stale or wrongly merged shadow shows only on the address of the next register write, so the bench runs several writes in a row with different codes. If the code latch is wrong, the written code follows inputs that change in the middle of a sequence.

// File: rtl/rtt_seq_pkg.sv
package rtt_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_OFF_WAIT = 3'd1,
        ST_ISSUE    = 3'd2,
        ST_MOD_WAIT = 3'd3,
        ST_DONE     = 3'd4
    } seq_state_e;

    // command encoding {ras_n, cas_n, we_n}
    localparam logic [2:0] CMD_NOP = 3'b111;
    localparam logic [2:0] CMD_MRS = 3'b000;

    localparam int MAX_ADDR_W = 16;
    localparam int MAX_BANK_W = 3;
    localparam int RTT_HI_BIT = 6;
    localparam int RTT_LO_BIT = 2;
    localparam logic [MAX_BANK_W-1:0] BANK_TERM_REG = 3'd1;

    typedef struct packed {
        logic [2:0]            cmd;
        logic [MAX_BANK_W-1:0] bank;
        logic [MAX_ADDR_W-1:0] addr;
    } cmd_bus_t;

    function automatic logic [MAX_ADDR_W-1:0] merge_rtt(
        input logic [MAX_ADDR_W-1:0] base,
        input logic [1:0]            code
    );
        logic [MAX_ADDR_W-1:0] r;
        r = base;
        r[RTT_HI_BIT] = code[1];
        r[RTT_LO_BIT] = code[0];
        return r;
    endfunction

endpackage

// File: rtl/rtt_seq_timer.sv
module rtt_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/rtt_seq_fsm.sv
module rtt_seq_fsm
    import rtt_seq_pkg::*;
#(
    parameter int T_AOFD    = 3,
    parameter int T_MOD_MAX = 12,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             timer_zero,
    output seq_state_e       state,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val
);
    localparam logic [CNT_W-1:0] AOFD_LOAD = CNT_W'(T_AOFD - 1);
    localparam logic [CNT_W-1:0] MOD_LOAD  = CNT_W'(T_MOD_MAX - 1);

    seq_state_e nxt;

    always_comb begin
        nxt        = state;
        accept     = 1'b0;
        timer_load = 1'b0;
        timer_val  = AOFD_LOAD;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    accept     = 1'b1;
                    timer_load = 1'b1;
                    nxt        = ST_OFF_WAIT;
                end
            end
            ST_OFF_WAIT: if (timer_zero) nxt = ST_ISSUE;
            ST_ISSUE: begin
                timer_load = 1'b1;
                timer_val  = MOD_LOAD;
                nxt        = ST_MOD_WAIT;
            end
            ST_MOD_WAIT: if (timer_zero) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/rtt_cmd_encode.sv
module rtt_cmd_encode
    import rtt_seq_pkg::*;
#(
    parameter int              ADDR_W    = 14,
    parameter logic [ADDR_W-1:0] EMR1_INIT = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state,
    input  logic [1:0] code,
    output cmd_bus_t   bus
);
    localparam logic [MAX_ADDR_W-1:0] INIT_WIDE = MAX_ADDR_W'(EMR1_INIT);
    localparam logic [MAX_ADDR_W-1:0] ADDR_MASK = MAX_ADDR_W'((1 << ADDR_W) - 1);

    logic [MAX_ADDR_W-1:0] shadow;
    logic [MAX_ADDR_W-1:0] write_word;

    assign write_word = merge_rtt(shadow, code) & ADDR_MASK;

    always_ff @(posedge clk) begin
        if (rst)                    shadow <= INIT_WIDE;
        else if (state == ST_ISSUE) shadow <= write_word;
    end

    always_comb begin
        bus.cmd  = CMD_NOP;
        bus.bank = '0;
        bus.addr = '0;
        if (state == ST_ISSUE) begin
            bus.cmd  = CMD_MRS;
            bus.bank = BANK_TERM_REG;
            bus.addr = write_word;
        end
    end
endmodule

// File: rtl/rtt_update_seq.sv
module rtt_update_seq
    import rtt_seq_pkg::*;
#(
    parameter int                T_AOFD    = 3,
    parameter int                T_MOD_MAX = 12,
    parameter int                ADDR_W    = 14,
    parameter int                BANK_W    = 3,
    parameter logic [ADDR_W-1:0] EMR1_INIT = 14'h2081
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        rtt_i,
    output logic              ack_o,
    input  logic              odt_owner_i,
    output logic              odt_o,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int MAX_T = (T_AOFD > T_MOD_MAX) ? T_AOFD : T_MOD_MAX;
    localparam int CNT_W = $clog2(MAX_T + 1);

    seq_state_e       state;
    logic             accept;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_zero;
    logic [1:0]       code_q;
    cmd_bus_t         bus;

    rtt_seq_fsm #(.T_AOFD(T_AOFD), .T_MOD_MAX(T_MOD_MAX), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .req(req_i), .timer_zero(timer_zero),
        .state(state), .accept(accept), .timer_load(timer_load), .timer_val(timer_val)
    );

    rtt_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val), .zero(timer_zero)
    );

    always_ff @(posedge clk) begin
        if (rst)         code_q <= 2'b00;
        else if (accept) code_q <= rtt_i;
    end

    rtt_cmd_encode #(.ADDR_W(ADDR_W), .EMR1_INIT(EMR1_INIT)) u_enc (
        .clk(clk), .rst(rst), .state(state), .code(code_q), .bus(bus)
    );

    assign odt_o  = (state == ST_IDLE) ? odt_owner_i : 1'b0;
    assign ack_o  = (state == ST_DONE);
    assign cmd_o  = bus.cmd;
    assign bank_o = bus.bank[BANK_W-1:0];
    assign addr_o = bus.addr[ADDR_W-1:0];
endmodule

// File: rtl/rtt_seq_checker.sv
module rtt_seq_checker #(
    parameter int T_AOFD    = 3,
    parameter int T_MOD_MAX = 12,
    parameter int ADDR_W    = 14,
    parameter int BANK_W    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_o,
    input logic              odt_o,
    input logic [2:0]        cmd_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [ADDR_W-1:0] addr_o
);
    localparam int LR_W = $clog2(T_AOFD + 2);
    localparam int SM_W = $clog2(T_MOD_MAX + 3);
    localparam logic [LR_W-1:0] LR_CAP = LR_W'(T_AOFD);
    localparam logic [SM_W-1:0] SM_CAP = SM_W'(T_MOD_MAX + 2);
    localparam logic [SM_W-1:0] SM_ACK = SM_W'(T_MOD_MAX + 1);

    logic [LR_W-1:0] low_run;
    logic [SM_W-1:0] since_mrs;
    logic            is_mrs;

    assign is_mrs = (cmd_o == 3'b000);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= '0;
            since_mrs <= '0;
        end else begin
            if (odt_o)                 low_run <= '0;
            else if (low_run < LR_CAP) low_run <= low_run + 1'b1;
            if (is_mrs)                  since_mrs <= SM_W'(1);
            else if (since_mrs != '0 && since_mrs < SM_CAP) since_mrs <= since_mrs + 1'b1;
        end
    end

    // R3: termination is off while the register write is on the bus
    a_r3_odt_low_at_write: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> !odt_o);
    // R3: termination still off in the acknowledge cycle
    a_r3_odt_low_at_ack: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !odt_o);
    // R4: turn-off delay fully elapsed before the write
    a_r4_aofd_elapsed: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (low_run >= LR_CAP));
    // R4: write addresses the termination register
    a_r4_bank_select: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (bank_o == BANK_W'(1)));
    // R6: write is followed by NOP
    a_r6_nop_after_write: assert property (@(posedge clk) disable iff (rst)
        is_mrs |=> (cmd_o == 3'b111));
    // R6: acknowledge is a single-cycle pulse
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    // R6: acknowledge lands exactly after the full update window
    a_r6_window_length: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (since_mrs == SM_ACK));
    // R3: no rising termination inside the update window
    a_r3_window_odt_low: assert property (@(posedge clk) disable iff (rst)
        (since_mrs != '0 && since_mrs <= SM_ACK) |-> !odt_o);
endmodule

bind rtt_update_seq rtt_seq_checker #(
    .T_AOFD(T_AOFD), .T_MOD_MAX(T_MOD_MAX), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst(rst), .ack_o(ack_o), .odt_o(odt_o),
    .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o)
);

// File: tb/tb_rtt_update_seq.sv
module tb_rtt_update_seq;
    localparam int          T_AOFD    = 3;
    localparam int          T_MOD_MAX = 12;
    localparam int          ADDR_W    = 14;
    localparam int          BANK_W    = 3;
    localparam logic [13:0] INIT      = 14'h2081;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_i = 1'b0;
    logic [1:0]        rtt_i = 2'b00;
    logic              odt_owner_i = 1'b1;
    logic              ack_o, odt_o;
    logic [2:0]        cmd_o;
    logic [BANK_W-1:0] bank_o;
    logic [ADDR_W-1:0] addr_o;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic        odt;
        logic [2:0]  cmd;
        logic [2:0]  bank;
        logic [13:0] addr;
        logic        ack;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [13:0] model_shadow = INIT;

    rtt_update_seq #(.T_AOFD(T_AOFD), .T_MOD_MAX(T_MOD_MAX), .ADDR_W(ADDR_W),
                     .BANK_W(BANK_W), .EMR1_INIT(INIT)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .rtt_i(rtt_i), .ack_o(ack_o),
        .odt_owner_i(odt_owner_i), .odt_o(odt_o), .cmd_o(cmd_o),
        .bank_o(bank_o), .addr_o(addr_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic odt, input logic [2:0] cmd, input logic [2:0] bank,
                        input logic [13:0] addr, input logic ack, input string tag);
        exp_t e;
        e.odt = odt; e.cmd = cmd; e.bank = bank; e.addr = addr; e.ack = ack; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: compare one expected item per cycle, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(odt_o == e.odt, e.tag, "odt", 32'(odt_o), 32'(e.odt));
            check(cmd_o == e.cmd, e.tag, "cmd", 32'(cmd_o), 32'(e.cmd));
            check(bank_o == e.bank, e.tag, "bank", 32'(bank_o), 32'(e.bank));
            check(addr_o == e.addr, e.tag, "addr", 32'(addr_o), 32'(e.addr));
            check(ack_o == e.ack, e.tag, "ack", 32'(ack_o), 32'(e.ack));
        end
    end

    // driver: request one update, optionally holding req and changing the code (R7)
    task automatic run_seq(input logic [1:0] code, input int hold,
                           input logic [1:0] alt, input string wtag);
        logic [13:0] w;
        @(posedge clk); #1;
        req_i = 1'b1; rtt_i = code; odt_owner_i = 1'b1;
        w = model_shadow; w[6] = code[1]; w[2] = code[0];
        push(1'b1, 3'b111, 3'd0, 14'd0, 1'b0, "R2");                  // accepting cycle
        for (int i = 0; i < T_AOFD; i++) push(1'b0, 3'b111, 3'd0, 14'd0, 1'b0, "R3");
        push(1'b0, 3'b000, 3'd1, w, 1'b0, wtag);                      // R4 R5 write
        for (int i = 0; i < T_MOD_MAX; i++) push(1'b0, 3'b111, 3'd0, 14'd0, 1'b0, "R6");
        push(1'b0, 3'b111, 3'd0, 14'd0, 1'b1, "R6");                  // ack
        push(1'b1, 3'b111, 3'd0, 14'd0, 1'b0, "R8");                  // idle again
        model_shadow = w;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
            rtt_i = alt;
        end
        @(posedge clk); #1;
        req_i = 1'b0;
        wait (sbq.size() == 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check(odt_o == 1'b1 && cmd_o == 3'b111 && ack_o == 1'b0, "R1", "reset outputs",
              {28'd0, odt_o, cmd_o}, 32'hF);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(bank_o == 0 && addr_o == 0, "R1", "idle bus after reset",
              32'(addr_o), 32'd0);
        // R2: pass-through while idle
        odt_owner_i = 1'b0;
        #0.5 check(odt_o == 1'b0, "R2", "odt follows owner low", 32'(odt_o), 32'd0);
        odt_owner_i = 1'b1;
        #0.5 check(odt_o == 1'b1, "R2", "odt follows owner high", 32'(odt_o), 32'd1);
        run_seq(2'b11, 0, 2'b00, "R5");
        run_seq(2'b01, 3, 2'b10, "R7");   // R7: mid-sequence input changes ignored
        run_seq(2'b00, 0, 2'b00, "R8");   // R8: shadow kept, bits 6/2 cleared
        run_seq(2'b10, 0, 2'b00, "R5");
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule